// File: doc/BRIEF.md
# PCI Configuration Address/Data Port Unit

This block serves the indirect two-register scheme for reaching PCI configuration space from a small I/O port bus. Software first writes a 32-bit selector to port 0xCF8. That selector holds an enable bit, a bus number, a device/function number and a register offset. Software then reads or writes through a four-byte data window at ports 0xCFC to 0xCFF. Window traffic reaches a 256-byte configuration array inside the block, which stands for a single local function. Any access the block does not claim is sent unchanged to a generic I/O port, and that port's read data is returned to the requester.

Each request is a single-cycle read or write strobe. Every request, whether accepted, rejected or passed on, is answered by a one-cycle acknowledge on the next cycle, with read data valid in that same cycle. The local bus and device/function numbers come from strap inputs. The block captures them on the first clock edge after reset is released and ignores them after that.

Top module: `pcicfg_port_unit`

## Requirements
- R1: After reset, io_ack is 0, io_rdata is 0 and the selector register reads 0x00000000.
- R2: A dword access (size code 2) to port 0xCF8 reads or writes the full 32-bit selector. Any other size at 0xCF8 is not claimed by the block.
- R3: The block claims ports 0xCFC to 0xCFF. Such an access is decoded only if port plus byte count is at most 0xD00. A claimed access that overruns this limit reads 0xFFFFFFFF and its write is dropped.
- R4: When selector bit 31 is 0, window reads return 0xFFFFFFFF and window writes leave the configuration array unchanged.
- R5: The selector's bus field (bits 23:16) and device/function field (bits 15:8) must both equal the strap values captured on the first clock after reset. On a mismatch, reads return 0xFFFFFFFF and writes are dropped. Strap changes after that first clock have no effect.
- R6: The effective offset is selector bits 7:0 plus (port − 0xCFC), modulo 256. Byte i of a multi-byte access sits at effective offset + i, modulo 256, and maps to data bits 8i+7:8i (little-endian).
- R7: Size code 0 is one byte, code 1 is two bytes, and codes 2 and 3 are four bytes. Read data bytes above the access size are 0.
- R8: io_ack is 1 in exactly the cycle after each io_rd or io_wr strobe and 0 otherwise. io_rdata is valid while io_ack is 1.
- R9: An access the block does not claim drives ext_rd or ext_wr in the same cycle, with ext_addr, ext_size and ext_wdata equal to the request. ext_rdata is returned with the acknowledge. A claimed access never drives ext_rd or ext_wr.
- R10: The configuration array reads as all zeros after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_bus | input | 8 | Local bus number, captured after reset |
| strap_devfn | input | 8 | Local device/function number, captured after reset |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | Size code: 0 byte, 1 word, 2/3 dword |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_wdata | input | 32 | Write data, little-endian lanes |
| io_rdata | output | 32 | Read data, valid with io_ack |
| io_ack | output | 1 | One-cycle acknowledge |
| ext_rd | output | 1 | Pass-through read strobe |
| ext_wr | output | 1 | Pass-through write strobe |
| ext_addr | output | 16 | Pass-through port address |
| ext_size | output | 2 | Pass-through size code |
| ext_wdata | output | 32 | Pass-through write data |
| ext_rdata | input | 32 | Pass-through read data |

## Verification
The hardest cases to reach from the ports are combinations in which the selector's offset field, the window port and the access size together make the access run past the end of the window, or wrap past byte 255 of the configuration array. The bench first fills the whole array with an arithmetic pattern, then reads back every offset-field value combined with every window port and every size code. Each result is compared against a byte-level shadow copy held in the bench. Rejected writes, caused by a cleared enable bit, a wrong bus, a wrong device/function or a window overrun, are each followed by a good read of the targeted bytes to show that nothing changed.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam int SEL_PORT  = 'hCF8;
  localparam int WIN_BASE  = 'hCFC;
  localparam int WIN_LAST  = 'hCFF;
  localparam int WIN_LIMIT = 'hD00;
  localparam int LANES     = 4;
  localparam int SPACE_BYTES = 256;

  typedef enum logic [1:0] {
    CLS_EXT     = 2'd0,
    CLS_SEL     = 2'd1,
    CLS_WIN_OK  = 2'd2,
    CLS_WIN_BAD = 2'd3
  } acc_cls_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pcicfg_decode.sv
module pcicfg_decode
  import pcicfg_pkg::*;
#(
  parameter int IO_AW = 16
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic             sel_en,
  input  logic [7:0]       sel_bus,
  input  logic [7:0]       sel_devfn,
  input  logic [7:0]       sel_off,
  input  logic [7:0]       local_bus,
  input  logic [7:0]       local_devfn,
  output acc_cls_e         cls,
  output logic [7:0]       cfg_off,
  output logic [2:0]       nbytes
);
  logic [IO_AW:0] span_end;
  logic           is_sel;
  logic           in_win;
  logic           fits;
  logic           target_ok;

  always_comb begin
    nbytes    = size_bytes(io_size);
    span_end  = {1'b0, io_addr} + (IO_AW+1)'(nbytes);
    is_sel    = (io_addr == IO_AW'(SEL_PORT)) && (nbytes == 3'd4);
    in_win    = (io_addr >= IO_AW'(WIN_BASE)) && (io_addr <= IO_AW'(WIN_LAST));
    fits      = span_end <= (IO_AW+1)'(WIN_LIMIT);
    target_ok = sel_en && (sel_bus == local_bus) && (sel_devfn == local_devfn);
    cfg_off   = sel_off + {6'd0, io_addr[1:0]};
    if (is_sel)                  cls = CLS_SEL;
    else if (!in_win)            cls = CLS_EXT;
    else if (fits && target_ok)  cls = CLS_WIN_OK;
    else                         cls = CLS_WIN_BAD;
  end
endmodule

// File: rtl/pcicfg_select.sv
module pcicfg_select (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_we,
  input  logic [31:0] sel_wdata,
  input  logic [7:0]  strap_bus,
  input  logic [7:0]  strap_devfn,
  output logic [31:0] sel_q,
  output logic [7:0]  local_bus,
  output logic [7:0]  local_devfn
);
  logic [31:0] sel_d;
  logic        taken_q;

  always_comb begin
    sel_d = sel_we ? sel_wdata : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_we) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q     <= 1'b0;
      local_bus   <= '0;
      local_devfn <= '0;
    end else if (!taken_q) begin
      taken_q     <= 1'b1;
      local_bus   <= strap_bus;
      local_devfn <= strap_devfn;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(sel_q)); // R2

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |=> ($stable(local_bus) && $stable(local_devfn))); // R5
endmodule

// File: rtl/pcicfg_space.sv
module pcicfg_space
  import pcicfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [7:0]  off,
  input  logic [2:0]  nbytes,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic [7:0] mem_q [SPACE_BYTES];
  logic [7:0] mem_d [SPACE_BYTES];
  logic [LANES-1:0]       lane_en;
  logic [LANES-1:0][7:0]  lane_off;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g]          = 3'(g) < nbytes;
    assign lane_off[g]         = off + 8'(g);
    assign rdata[8*g +: 8]     = lane_en[g] ? mem_q[lane_off[g]] : 8'd0;
  end

  always_comb begin
    mem_d = mem_q;
    for (int l = 0; l < LANES; l++) begin
      if (we && lane_en[l]) mem_d[lane_off[l]] = wdata[8*l +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SPACE_BYTES; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q <= mem_d;
    end
  end

  AST_SPACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(we) && $stable(off) && $stable(nbytes)) |-> $stable(rdata)); // R4
endmodule

// File: rtl/pcicfg_port_unit.sv
module pcicfg_port_unit
  import pcicfg_pkg::*;
#(
  parameter int IO_AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       strap_bus,
  input  logic [7:0]       strap_devfn,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  output logic             io_ack,
  output logic             ext_rd,
  output logic             ext_wr,
  output logic [IO_AW-1:0] ext_addr,
  output logic [1:0]       ext_size,
  output logic [31:0]      ext_wdata,
  input  logic [31:0]      ext_rdata
);
  acc_cls_e    cls;
  logic [31:0] sel_q;
  logic [7:0]  local_bus, local_devfn;
  logic [7:0]  cfg_off;
  logic [2:0]  nbytes;
  logic [31:0] space_rdata;
  logic        strobe;
  logic [31:0] rdata_d;

  pcicfg_decode #(.IO_AW(IO_AW)) u_decode (
    .io_addr(io_addr), .io_size(io_size),
    .sel_en(sel_q[31]), .sel_bus(sel_q[23:16]), .sel_devfn(sel_q[15:8]),
    .sel_off(sel_q[7:0]), .local_bus(local_bus), .local_devfn(local_devfn),
    .cls(cls), .cfg_off(cfg_off), .nbytes(nbytes)
  );

  pcicfg_select u_select (
    .clk(clk), .rst_n(rst_n),
    .sel_we(io_wr && (cls == CLS_SEL)), .sel_wdata(io_wdata),
    .strap_bus(strap_bus), .strap_devfn(strap_devfn),
    .sel_q(sel_q), .local_bus(local_bus), .local_devfn(local_devfn)
  );

  pcicfg_space u_space (
    .clk(clk), .rst_n(rst_n),
    .we(io_wr && (cls == CLS_WIN_OK)), .off(cfg_off), .nbytes(nbytes),
    .wdata(io_wdata), .rdata(space_rdata)
  );

  assign strobe    = io_rd || io_wr;
  assign ext_rd    = io_rd && (cls == CLS_EXT);
  assign ext_wr    = io_wr && (cls == CLS_EXT);
  assign ext_addr  = io_addr;
  assign ext_size  = io_size;
  assign ext_wdata = io_wdata;

  always_comb begin
    rdata_d = io_rdata;
    if (io_rd) begin
      case (cls)
        CLS_SEL:    rdata_d = sel_q;
        CLS_WIN_OK: rdata_d = space_rdata;
        CLS_EXT:    rdata_d = ext_rdata;
        default:    rdata_d = '1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_ack <= 1'b0;
    end else begin
      io_ack <= strobe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rdata <= '0;
    end else if (io_rd) begin
      io_rdata <= rdata_d;
    end
  end

  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> io_ack); // R8

  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !io_ack); // R8

  AST_REJECT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (cls == CLS_WIN_BAD)) |=> (io_rdata == 32'hFFFF_FFFF)); // R3
endmodule

// File: tb/pcicfg_port_unit_test.sv
module pcicfg_port_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LBUS = 8'h05;
  localparam logic [7:0] LDFN = 8'h2B;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  strap_bus, strap_devfn;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic        io_rd, io_wr;
  logic [31:0] io_wdata, io_rdata;
  logic        io_ack;
  logic        ext_rd, ext_wr;
  logic [15:0] ext_addr;
  logic [1:0]  ext_size;
  logic [31:0] ext_wdata, ext_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] shadow [256];
  logic [31:0] cur_sel;

  logic [31:0] r_data;
  bit r_ack, r_ext;
  logic [15:0] r_eaddr;
  logic [1:0]  r_esize;
  logic [31:0] r_ewdata;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ext_rdata = {ext_addr, ~ext_addr};

  pcicfg_port_unit uut (
    .clk(clk), .rst_n(rst_n), .strap_bus(strap_bus), .strap_devfn(strap_devfn),
    .io_addr(io_addr), .io_size(io_size), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_size(ext_size),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit is_wr, input logic [15:0] a, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    io_addr = a; io_size = sz; io_wdata = wd;
    io_rd = !is_wr; io_wr = is_wr;
    #1;
    r_ext = ext_rd || ext_wr;
    r_eaddr = ext_addr; r_esize = ext_size; r_ewdata = ext_wdata;
    @(negedge clk);
    r_ack = io_ack; r_data = io_rdata;
    io_rd = 0; io_wr = 0;
  endtask

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit accepted(input logic [31:0] s, input int p, input logic [1:0] sz);
    return s[31] && s[23:16] == LBUS && s[15:8] == LDFN && (p + nb(sz) <= 4);
  endfunction

  function automatic logic [31:0] model_rd(input logic [31:0] s, input int p, input logic [1:0] sz);
    logic [31:0] v = '0;
    if (!accepted(s, p, sz)) return 32'hFFFF_FFFF;
    for (int i = 0; i < nb(sz); i++) v[8*i +: 8] = shadow[(int'(s[7:0]) + p + i) & 255];
    return v;
  endfunction

  task automatic set_sel(input logic [31:0] v);
    xfer(1, 16'hCF8, 2'd2, v);
    cur_sel = v;
    chk(r_ack && !r_ext, "R8 R9 selector write ack", {30'd0, r_ack, r_ext}, 32'h2);
  endtask

  task automatic win_wr(input int p, input logic [1:0] sz, input logic [31:0] v);
    xfer(1, 16'(16'hCFC + p), sz, v);
    if (accepted(cur_sel, p, sz))
      for (int i = 0; i < nb(sz); i++) shadow[(int'(cur_sel[7:0]) + p + i) & 255] = v[8*i +: 8];
  endtask

  task automatic win_rd_chk(input int p, input logic [1:0] sz, input string req);
    logic [31:0] e;
    e = model_rd(cur_sel, p, sz);
    xfer(0, 16'(16'hCFC + p), sz, 32'h0);
    chk(r_data == e && r_ack && !r_ext, req, r_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; strap_bus = LBUS; strap_devfn = LDFN;
    io_addr = 0; io_size = 0; io_rd = 0; io_wr = 0; io_wdata = 0;
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(io_ack == 0 && io_rdata == 0, "R1 reset outputs", io_rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    strap_bus = 8'h77; strap_devfn = 8'h11;   // R5: late strap change must be ignored

    xfer(0, 16'hCF8, 2'd2, 0);
    chk(r_data == 32'h0 && r_ack, "R1 selector reset value", r_data, 32'h0);
    chk(!r_ext, "R9 selector read not forwarded", {31'd0, r_ext}, 32'h0);
    @(negedge clk);
    chk(io_ack == 0, "R8 ack lasts one cycle", {31'd0, io_ack}, 32'h0);

    set_sel(32'h5A3C_96E1);
    xfer(0, 16'hCF8, 2'd2, 0);
    chk(r_data == 32'h5A3C_96E1, "R2 selector read back", r_data, 32'h5A3C_96E1);

    // R10: array is zero after reset
    for (int o = 0; o < 256; o += 4) begin
      set_sel({1'b1, 7'd0, LBUS, LDFN, 8'(o)});
      win_rd_chk(0, 2'd2, "R10 zero after reset");
    end

    // fill with dword writes
    for (int o = 0; o < 256; o += 4) begin
      logic [31:0] v;
      for (int i = 0; i < 4; i++) v[8*i +: 8] = 8'(((o + i) * 29 + 7) ^ ((o + i) >> 3));
      set_sel({1'b1, 7'd0, LBUS, LDFN, 8'(o)});
      win_wr(0, 2'd2, v);
    end

    // sub-dword and overrunning writes at every window port (R3, R6, R7)
    for (int o = 1; o < 256; o += 13) begin
      set_sel({1'b1, 7'd0, LBUS, LDFN, 8'(o)});
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 3; s++)
          win_wr(p, 2'(s), 32'(o * 977 + p * 131 + s * 17) ^ 32'hC3A5_0F96);
    end

    // exhaustive read sweep: offset field x port x size code
    for (int o = 0; o < 256; o++) begin
      set_sel({1'b1, 7'd0, LBUS, LDFN, 8'(o)});
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 4; s++)
          win_rd_chk(p, 2'(s), (p + nb(2'(s)) > 4) ? "R3 overrun" : "R6 R7 window read");
    end

    // R6: wrap past offset 255
    set_sel({1'b1, 7'd0, LBUS, LDFN, 8'hFF});
    win_rd_chk(0, 2'd2, "R6 wrap read");
    win_wr(0, 2'd2, 32'h8877_6655);
    set_sel({1'b1, 7'd0, LBUS, LDFN, 8'h00});
    win_rd_chk(0, 2'd2, "R6 wrap write lands at low offsets");

    // R4: enable clear
    set_sel({1'b0, 7'd0, LBUS, LDFN, 8'h40});
    win_rd_chk(0, 2'd2, "R4 disabled read ones");
    chk(r_data == 32'hFFFF_FFFF, "R4 disabled read value", r_data, 32'hFFFF_FFFF);
    win_wr(0, 2'd2, 32'hDEAD_BEEF);
    set_sel({1'b1, 7'd0, LBUS, LDFN, 8'h40});
    win_rd_chk(0, 2'd2, "R4 disabled write dropped");

    // R5: wrong bus, wrong devfn, and the late strap values
    set_sel({1'b1, 7'd0, LBUS ^ 8'h01, LDFN, 8'h40});
    win_rd_chk(0, 2'd2, "R5 wrong bus read");
    win_wr(0, 2'd2, 32'h1234_5678);
    set_sel({1'b1, 7'd0, LBUS, LDFN ^ 8'h08, 8'h40});
    win_rd_chk(0, 2'd1, "R5 wrong devfn read");
    win_wr(2, 2'd1, 32'h0000_ABCD);
    set_sel({1'b1, 7'd0, 8'h77, 8'h11, 8'h40});
    win_rd_chk(0, 2'd2, "R5 late straps not used");
    win_wr(0, 2'd2, 32'h0BAD_F00D);
    set_sel({1'b1, 7'd0, LBUS, LDFN, 8'h40});
    win_rd_chk(0, 2'd2, "R5 rejected writes dropped");

    // R3: overrun write dropped
    win_wr(3, 2'd1, 32'h0000_EEEE);
    win_rd_chk(0, 2'd2, "R3 overrun write dropped");

    // R9: pass-through
    xfer(0, 16'h0080, 2'd0, 0);
    chk(r_ext && r_eaddr == 16'h0080 && r_esize == 2'd0, "R9 ext read strobe", {r_eaddr, 14'd0, r_esize}, {16'h0080, 16'h0});
    chk(r_data == {16'h0080, 16'hFF7F} && r_ack, "R9 ext read data", r_data, {16'h0080, 16'hFF7F});
    xfer(1, 16'h0D00, 2'd2, 32'hCAFE_0123);
    chk(r_ext && r_eaddr == 16'h0D00 && r_ewdata == 32'hCAFE_0123 && r_ack, "R9 ext write", r_ewdata, 32'hCAFE_0123);
    xfer(0, 16'hCF8, 2'd0, 0);
    chk(r_ext && r_data == {16'h0CF8, 16'hF307}, "R2 R9 byte at selector port forwarded", r_data, {16'h0CF8, 16'hF307});
    xfer(1, 16'hCFB, 2'd0, 32'h0000_0011);
    chk(r_ext, "R9 port below window forwarded", {31'd0, r_ext}, 32'h1);
    xfer(0, 16'hCF8, 2'd2, 0);
    chk(r_data == cur_sel, "R2 selector unchanged by forwarded traffic", r_data, cur_sel);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule